// File: doc/BRIEF.md
# Dual-Output Prioritised Interrupt Controller

This block gathers 64 level inputs into a pending vector and presents two interrupt lines to a processor: a normal line and a fast line. Each source has an enable bit, a type bit that routes it to the fast line, and a 4-bit priority. The normal line is gated by a 5-bit threshold register. Software reaches all of this state through a simple 32-bit register bus addressed in words.

Two status registers tell software which source to service. A read of either one also acknowledges the source it returns by clearing that source's pending bit. The normal status register names the highest-priority normal source. The fast status register names the lowest-numbered fast source. Sources can be enabled or disabled one at a time by writing their number. Force registers let software overwrite the pending vector directly.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: A rising edge on a source input sets its pending bit and a falling edge clears it. An acknowledge by a status read in the same cycle overrides a rising edge on that source.
- R2: `fiq_o` is high one cycle after the state holds any source that is pending, enabled and of fast type (type bit 1).
- R3: `irq_o` is high one cycle after the state holds a pending, enabled, normal-type source whose priority is strictly greater than the threshold. When the threshold equals 31, any such source is enough.
- R4: A write to word offset 2 sets the enable bit numbered by `wdata[5:0]`, and a write to offset 3 clears it. Both offsets read as zero.
- R5: The 64-bit vectors are split into word pairs, with bits 63:32 at the lower offset. Enable is at 4/5 and type at 6/7, and both can be read and written. Pending is at 18/19 and is read-only. Force is at 20/21: a write overwrites that half of pending, and a read returns zero.
- R6: Priority words sit at offsets 8 to 15, with offset k holding word 15-k. Source i's priority is nibble i%8 (bits 4*(i%8)+3 : 4*(i%8)) of word i/8.
- R7: A read of offset 16 returns `{index[15:0], priority[15:0]}` for the normal source with the highest priority, choosing the highest index on a tie, and clears its pending bit. With no candidate the read returns 0xFFFFFFFF.
- R8: A read of offset 17 returns the index of the lowest-numbered fast candidate and clears its pending bit. With no candidate the read returns 0xFFFFFFFF.
- R9: Offsets 22/23 read pending & enable & ~type, and offsets 24/25 read pending & enable & type. Writes to offsets 16 to 19 and 22 to 25 change no state.
- R10: Reset sets the threshold (offset 1, 5 bits) to 0x1F and clears all other state and both outputs.
- R11: An access to an offset outside 0 to 25 and outside the vector area 64 to 191 reads zero and changes nothing. `bus_err` pulses for one cycle after it. Accesses to the vector area read zero, ignore writes and raise no error.
- R12: Read data appears on `bus_rdata` one cycle after `bus_rd`. A cycle that carries both a read and a write performs only the read. Offset 0 stores the written bits selected by `CTRL_MASK`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an access to an undefined offset |
| src_lvl | input | 64 | Source level inputs |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
Three patterns exercise the normal resolver. The first is two sources tied at the top priority plus a weaker one; it tells the highest-index tie rule apart from a lowest-index one. The second sets the threshold equal to and then one below the surviving source's priority, which separates a strict compare from a non-strict one. The third sets the threshold to 31, which shows the all-pass case apart from an ordinary compare. The fast path runs with a single source and with two sources forced together, which separates lowest-index selection from the normal rule. One cycle carries an acknowledge together with a rising edge on the same source, which shows which of the two wins.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC        = 64;
  localparam int IDX_W       = $clog2(NSRC);
  localparam int PRIO_W      = 4;
  localparam int MASK_W      = 5;
  localparam int DW          = 32;
  localparam int HALF        = NSRC / 2;
  localparam int PRIO_PER_W  = DW / PRIO_W;
  localparam int PRIO_WORDS  = NSRC / PRIO_PER_W;
  localparam int PSEL_W      = $clog2(PRIO_WORDS);
  localparam int ADDR_W      = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'd0;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'd1;
  localparam logic [ADDR_W-1:0] OFS_ENNUM  = 8'd2;
  localparam logic [ADDR_W-1:0] OFS_DISNUM = 8'd3;
  localparam logic [ADDR_W-1:0] OFS_EN_HI  = 8'd4;
  localparam logic [ADDR_W-1:0] OFS_EN_LO  = 8'd5;
  localparam logic [ADDR_W-1:0] OFS_TY_HI  = 8'd6;
  localparam logic [ADDR_W-1:0] OFS_TY_LO  = 8'd7;
  localparam logic [ADDR_W-1:0] OFS_PRI_LO = 8'd8;
  localparam logic [ADDR_W-1:0] OFS_PRI_HI = 8'd15;
  localparam logic [ADDR_W-1:0] OFS_NSTAT  = 8'd16;
  localparam logic [ADDR_W-1:0] OFS_FSTAT  = 8'd17;
  localparam logic [ADDR_W-1:0] OFS_SRC_HI = 8'd18;
  localparam logic [ADDR_W-1:0] OFS_SRC_LO = 8'd19;
  localparam logic [ADDR_W-1:0] OFS_FRC_HI = 8'd20;
  localparam logic [ADDR_W-1:0] OFS_FRC_LO = 8'd21;
  localparam logic [ADDR_W-1:0] OFS_NPV_HI = 8'd22;
  localparam logic [ADDR_W-1:0] OFS_NPV_LO = 8'd23;
  localparam logic [ADDR_W-1:0] OFS_FPV_HI = 8'd24;
  localparam logic [ADDR_W-1:0] OFS_FPV_LO = 8'd25;
  localparam logic [ADDR_W-1:0] OFS_VEC_LO = 8'd64;
  localparam logic [ADDR_W-1:0] OFS_VEC_HI = 8'd191;
endpackage

// File: rtl/irqc_src_track.sv
module irqc_src_track #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/irqc_prio_tree.sv
// Balanced tournament: highest priority wins, the higher index wins a tie.
// N must be a power of two.
module irqc_prio_tree #(
  parameter int N  = 64,
  parameter int PW = 4,
  parameter int IW = 6
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio_flat,
  output logic            win_vld,
  output logic [PW-1:0]   win_prio,
  output logic [IW-1:0]   win_idx
);
  typedef struct packed {
    logic          v;
    logic [PW-1:0] p;
    logic [IW-1:0] i;
  } cand_t;

  function automatic cand_t pick(cand_t lo, cand_t hi);
    if (hi.v && (!lo.v || hi.p >= lo.p)) return hi;
    return lo;
  endfunction

  cand_t node [2*N-1];

  for (genvar g = 0; g < N; g++) begin : g_leaf
    assign node[N-1+g] = '{v: req[g], p: prio_flat[g*PW +: PW], i: IW'(g)};
  end

  for (genvar j = 0; j < N-1; j++) begin : g_node
    assign node[j] = pick(node[2*j+1], node[2*j+2]);
  end

  assign win_vld  = node[0].v;
  assign win_prio = node[0].p;
  assign win_idx  = node[0].i;
endmodule

// File: rtl/irqc_low_pick.sv
module irqc_low_pick #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic [N-1:0]  req,
  output logic          vld,
  output logic [IW-1:0] idx
);
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req[i]) begin
        vld = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import irqc_pkg::*;
#(
  parameter logic [DW-1:0] CTRL_MASK = 32'h0000_00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_err,
  input  logic [NSRC-1:0]   src_lvl,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam logic [MASK_W-1:0] MASK_ALL = '1;

  logic [NSRC-1:0]   pend, pend_next, en, fast;
  logic [DW-1:0]     ctrl;
  logic [MASK_W-1:0] mask_q;
  logic [DW-1:0]     prio_w [PRIO_WORDS];
  logic [NSRC*PRIO_W-1:0] prio_flat;

  logic [NSRC-1:0]   rise, fall, norm_req, fast_req;
  logic              n_vld, f_vld;
  logic [PRIO_W-1:0] n_prio;
  logic [IDX_W-1:0]  n_idx, f_idx;
  logic [DW-1:0]     nstat_val, fstat_val, rd_val;
  logic              known, in_pri, in_vec, rd_go, wr_go;
  logic [PSEL_W-1:0] pri_sel;

  irqc_src_track #(.N(NSRC)) u_track (
    .clk(clk), .rst(rst), .lvl(src_lvl), .rise(rise), .fall(fall)
  );

  for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_pflat
    assign prio_flat[w*DW +: DW] = prio_w[w];
  end

  assign norm_req = pend & en & ~fast;
  assign fast_req = pend & en & fast;

  irqc_prio_tree #(.N(NSRC), .PW(PRIO_W), .IW(IDX_W)) u_tree (
    .req(norm_req), .prio_flat(prio_flat),
    .win_vld(n_vld), .win_prio(n_prio), .win_idx(n_idx)
  );

  irqc_low_pick #(.N(NSRC), .IW(IDX_W)) u_low (
    .req(fast_req), .vld(f_vld), .idx(f_idx)
  );

  assign rd_go   = bus_rd;
  assign wr_go   = bus_wr & ~bus_rd;
  assign in_pri  = (bus_addr >= OFS_PRI_LO) && (bus_addr <= OFS_PRI_HI);
  assign in_vec  = (bus_addr >= OFS_VEC_LO) && (bus_addr <= OFS_VEC_HI);
  assign pri_sel = PSEL_W'(OFS_PRI_HI - bus_addr);
  assign known   = (bus_addr <= OFS_FPV_LO) || in_vec;

  assign nstat_val = n_vld ? {16'(n_idx), 16'(n_prio)} : '1;
  assign fstat_val = f_vld ? DW'(f_idx) : '1;

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      OFS_CTRL:   rd_val = ctrl;
      OFS_MASK:   rd_val = DW'(mask_q);
      OFS_EN_HI:  rd_val = en[NSRC-1:HALF];
      OFS_EN_LO:  rd_val = en[HALF-1:0];
      OFS_TY_HI:  rd_val = fast[NSRC-1:HALF];
      OFS_TY_LO:  rd_val = fast[HALF-1:0];
      OFS_NSTAT:  rd_val = nstat_val;
      OFS_FSTAT:  rd_val = fstat_val;
      OFS_SRC_HI: rd_val = pend[NSRC-1:HALF];
      OFS_SRC_LO: rd_val = pend[HALF-1:0];
      OFS_NPV_HI: rd_val = norm_req[NSRC-1:HALF];
      OFS_NPV_LO: rd_val = norm_req[HALF-1:0];
      OFS_FPV_HI: rd_val = fast_req[NSRC-1:HALF];
      OFS_FPV_LO: rd_val = fast_req[HALF-1:0];
      default:    if (in_pri) rd_val = prio_w[pri_sel];
    endcase
  end

  always_comb begin
    pend_next = (pend | rise) & ~fall;
    if (wr_go && bus_addr == OFS_FRC_HI) pend_next[NSRC-1:HALF] = bus_wdata;
    if (wr_go && bus_addr == OFS_FRC_LO) pend_next[HALF-1:0]    = bus_wdata;
    if (rd_go && bus_addr == OFS_NSTAT && n_vld) pend_next[n_idx] = 1'b0;
    if (rd_go && bus_addr == OFS_FSTAT && f_vld) pend_next[f_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      en        <= '0;
      fast      <= '0;
      ctrl      <= '0;
      mask_q    <= MASK_ALL;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
      for (int w = 0; w < PRIO_WORDS; w++) prio_w[w] <= '0;
    end else begin
      pend    <= pend_next;
      bus_err <= (rd_go | wr_go) & ~known;
      irq_o   <= n_vld && (mask_q == MASK_ALL || MASK_W'(n_prio) > mask_q);
      fiq_o   <= |fast_req;
      if (rd_go) bus_rdata <= rd_val;
      if (wr_go) begin
        case (bus_addr)
          OFS_CTRL:   ctrl <= bus_wdata & CTRL_MASK;
          OFS_MASK:   mask_q <= bus_wdata[MASK_W-1:0];
          OFS_ENNUM:  en[bus_wdata[IDX_W-1:0]] <= 1'b1;
          OFS_DISNUM: en[bus_wdata[IDX_W-1:0]] <= 1'b0;
          OFS_EN_HI:  en[NSRC-1:HALF]   <= bus_wdata;
          OFS_EN_LO:  en[HALF-1:0]      <= bus_wdata;
          OFS_TY_HI:  fast[NSRC-1:HALF] <= bus_wdata;
          OFS_TY_LO:  fast[HALF-1:0]    <= bus_wdata;
          default:    if (in_pri) prio_w[pri_sel] <= bus_wdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              bus_err,
  input logic              fiq_o,
  input logic [NSRC-1:0]   pend,
  input logic [NSRC-1:0]   en,
  input logic [NSRC-1:0]   fast,
  input logic [MASK_W-1:0] mask_q,
  input logic              n_vld,
  input logic [IDX_W-1:0]  n_idx,
  input logic              f_vld,
  input logic [IDX_W-1:0]  f_idx
);
  // R10
  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (mask_q == 5'h1F && en == '0 && pend == '0 && fast == '0));

  // R4
  a_r4_ennum_sets: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_addr == OFS_ENNUM) |=> en[$past(bus_wdata[IDX_W-1:0])]);

  a_r4_disnum_clears: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_addr == OFS_DISNUM) |=> !en[$past(bus_wdata[IDX_W-1:0])]);

  // R7
  a_r7_normal_ack: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_NSTAT && n_vld) |=> !pend[$past(n_idx)]);

  // R8
  a_r8_fast_ack: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_FSTAT && f_vld) |=> !pend[$past(f_idx)]);

  // R9
  a_r9_ro_writes: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && ((bus_addr >= OFS_NSTAT && bus_addr <= OFS_SRC_LO) ||
                           (bus_addr >= OFS_NPV_HI && bus_addr <= OFS_FPV_LO)))
    |=> ($stable(en) && $stable(fast) && $stable(mask_q)));

  // R11
  a_r11_err_after_access: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_rd || bus_wr));

  // R2
  a_r2_fiq_needs_fast: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> $past(fast != '0));
endmodule

bind irq_fiq_ctrl irqc_checker u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_err(bus_err), .fiq_o(fiq_o), .pend(pend), .en(en),
  .fast(fast), .mask_q(mask_q), .n_vld(n_vld), .n_idx(n_idx), .f_vld(f_vld),
  .f_idx(f_idx)
);

// File: tb/irq_fiq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_fiq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [63:0] src_lvl = '0;
  logic        irq_o, fiq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_fiq_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .src_lvl(src_lvl), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // {offset, write data, expected read-back}
  localparam logic [71:0] VT [12] = '{
    {8'd0,   32'hFFFF_FFFF, 32'h0000_00FF},
    {8'd1,   32'hFFFF_FFE3, 32'h0000_0003},
    {8'd4,   32'hA5A5_0001, 32'hA5A5_0001},
    {8'd5,   32'h0000_0003, 32'h0000_0003},
    {8'd6,   32'h0F00_0000, 32'h0F00_0000},
    {8'd7,   32'h8000_0001, 32'h8000_0001},
    {8'd8,   32'h1234_5678, 32'h1234_5678},
    {8'd15,  32'h8765_4321, 32'h8765_4321},
    {8'd2,   32'h0000_0005, 32'h0000_0000},
    {8'd20,  32'h0000_0001, 32'h0000_0000},
    {8'd99,  32'h0000_1234, 32'h0000_0000},
    {8'd70,  32'h0000_5555, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    do_reset();
    // R10 reset state
    chk("R10 irq_o after reset", 32'(irq_o), 32'd0);
    chk("R10 fiq_o after reset", 32'(fiq_o), 32'd0);
    rd(8'd1, r);  chk("R10 threshold reset", r, 32'h1F);
    rd(8'd5, r);  chk("R10 enable reset", r, 32'h0);

    // Table walk: R4 R5 R6 R11 R12 read-back
    for (int i = 0; i < 12; i++) begin
      wr(VT[i][71:64], VT[i][63:32]);
      rd(VT[i][71:64], r);
      chk($sformatf("table row %0d (R4 R5 R6 R11 R12)", i), r, VT[i][31:0]);
    end
    do_reset();

    // R1 edge-driven pending
    @(negedge clk); src_lvl[3] = 1'b1;
    rd(8'd19, r); chk("R1 rise sets pending", r, 32'h8);
    @(negedge clk); src_lvl[3] = 1'b0;
    rd(8'd19, r); chk("R1 fall clears pending", r, 32'h0);

    // R4 enable by number
    wr(8'd2, 32'h45); rd(8'd5, r); chk("R4 enable number", r, 32'h20);
    wr(8'd3, 32'h05); rd(8'd5, r); chk("R4 disable number", r, 32'h0);
    rd(8'd3, r); chk("R4 disable reg reads zero", r, 32'h0);

    // R2 / R8 fast path
    wr(8'd7, 32'h80); wr(8'd5, 32'h80);
    @(negedge clk); src_lvl[7] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2 fiq_o high", 32'(fiq_o), 32'd1);
    chk("R3 irq_o low with only fast", 32'(irq_o), 32'd0);
    rd(8'd25, r); chk("R9 fast view", r, 32'h80);
    rd(8'd23, r); chk("R9 normal view", r, 32'h0);
    rd(8'd17, r); chk("R8 fast status", r, 32'd7);
    rd(8'd19, r); chk("R8 ack cleared pending", r, 32'h0);
    chk("R2 fiq_o low after ack", 32'(fiq_o), 32'd0);
    rd(8'd17, r); chk("R8 fast status empty", r, 32'hFFFF_FFFF);
    wr(8'd7, 32'h90); wr(8'd5, 32'h90); wr(8'd21, 32'h90);
    rd(8'd17, r); chk("R8 lowest index first", r, 32'd4);
    rd(8'd17, r); chk("R8 next index", r, 32'd7);
    rd(8'd17, r); chk("R8 drained", r, 32'hFFFF_FFFF);
    @(negedge clk); src_lvl[7] = 1'b0;

    // R3 / R6 / R7 normal path
    wr(8'd7, 32'h0); wr(8'd5, 32'hFFFF_FFFF); wr(8'd4, 32'hFFFF_FFFF);
    wr(8'd15, 32'h0000_0500);   // source 2 priority 5
    wr(8'd14, 32'h0000_0900);   // source 10 priority 9
    wr(8'd10, 32'h0000_0009);   // source 40 priority 9
    wr(8'd1, 32'h8);
    wr(8'd21, 32'h404); wr(8'd20, 32'h100);
    @(negedge clk);
    chk("R3 irq_o above threshold", 32'(irq_o), 32'd1);
    rd(8'd22, r); chk("R5 R9 normal view high", r, 32'h100);
    rd(8'd23, r); chk("R9 normal view low", r, 32'h404);
    rd(8'd16, r); chk("R7 tie goes to higher index (R6 map)", r, 32'h0028_0009);
    rd(8'd16, r); chk("R7 second winner", r, 32'h000A_0009);
    @(negedge clk);
    chk("R3 irq_o low at or below threshold", 32'(irq_o), 32'd0);
    wr(8'd1, 32'h1F); @(negedge clk);
    chk("R3 threshold 31 passes all", 32'(irq_o), 32'd1);
    wr(8'd1, 32'h5); @(negedge clk);
    chk("R3 equal priority blocked", 32'(irq_o), 32'd0);
    wr(8'd1, 32'h4); @(negedge clk);
    chk("R3 one above passes", 32'(irq_o), 32'd1);
    rd(8'd16, r); chk("R7 last normal", r, 32'h0002_0005);
    rd(8'd16, r); chk("R7 empty", r, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R3 irq_o low when empty", 32'(irq_o), 32'd0);

    // R1 acknowledge beats a rising edge in the same cycle
    wr(8'd21, 32'h1000);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'd16; src_lvl[12] = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R7 status of source 12", bus_rdata, 32'h000C_0000);
    rd(8'd19, r); chk("R1 ack wins over rise", r, 32'h0);

    // R9 writes to read-only offsets
    wr(8'd23, 32'hFFFF); wr(8'd16, 32'hFF); wr(8'd19, 32'hFFFF);
    rd(8'd7, r);  chk("R9 type untouched", r, 32'h0);
    rd(8'd19, r); chk("R9 pending untouched", r, 32'h0);

    // R11 undefined offsets and vector area
    wr(8'd30, 32'h1);
    chk("R11 err pulse on write", 32'(bus_err), 32'd1);
    @(negedge clk);
    chk("R11 err one cycle", 32'(bus_err), 32'd0);
    rd(8'd30, r);
    chk("R11 undefined read zero", r, 32'h0);
    chk("R11 err pulse on read", 32'(bus_err), 32'd1);
    wr(8'd100, 32'h1);
    chk("R11 vector area no err", 32'(bus_err), 32'd0);
    rd(8'd1, r); chk("R11 threshold unchanged", r, 32'h4);

    // R12 read wins over write in the same cycle
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 8'd1; bus_wdata = 32'h7;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    chk("R12 read data", bus_rdata, 32'h4);
    rd(8'd1, r); chk("R12 write dropped", r, 32'h4);

    // R10 reset from a busy state
    @(negedge clk); src_lvl[12] = 1'b0;
    do_reset();
    rd(8'd1, r);  chk("R10 threshold after reset", r, 32'h1F);
    rd(8'd4, r);  chk("R10 enable high after reset", r, 32'h0);
    rd(8'd14, r); chk("R10 priority after reset", r, 32'h0);
    chk("R10 irq_o low", 32'(irq_o), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule